// File: doc/BRIEF.md
# Timed Interrupt Hold-Off Counter

This block sits next to a processor's interrupt controller. It blocks interrupt acceptance for a programmed number of instruction cycles. The count starts when the core executes an instruction that disables interrupts for N cycles. The core supplies three inputs: a strobe that is high on every cycle in which an instruction completes, a pulse that marks the disable instruction, and that instruction's N operand. The block returns an inhibit line, which the interrupt controller uses to gate acceptance, and a busy flag that software can read.

The disable instruction's own cycle is always blocked. A down-counter then holds the block for N more advancing cycles. A new disable instruction always reloads the counter, whether it arrives while the count is still running, on the exact cycle the count reaches zero, or later. The inhibit therefore never lapses when disable instructions are chained back to back.

Top module: `tid_holdoff`

## Requirements
- R1: While reset is asserted, and on the first cycles after its release with no issue pulse, both inhibit_o and busy_o are 0.
- R2: inhibit_o is 1 in any cycle in which issue_i is 1, with no register delay.
- R3: With adv_i high on every cycle, an issue with operand N>0 keeps inhibit_o high for exactly N+1 consecutive cycles, counting the issue cycle.
- R4: The count decreases only on cycles with adv_i high. Cycles with adv_i low hold both inhibit_o and busy_o unchanged while a count is running.
- R5: An issue while the count is non-zero reloads the count with the new operand, and inhibit_o stays high without a gap until the new count expires.
- R6: An issue on the cycle in which the count has just reached zero loads the new operand and keeps inhibit_o high with no gap.
- R7: An operand of 0 blocks only the issue cycle. busy_o stays 0 and inhibit_o is 0 on the following cycle.
- R8: busy_o is 1 exactly when the stored count is non-zero, which is from the cycle after an issue with N>0 until the count expires. Whenever busy_o is 1, inhibit_o is also 1.
- R9: An issue one or more cycles after the count has expired starts a fresh window of N+1 cycles.
- R10: The largest operand, 16383 (14 bits), gives a window of 16384 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously outside the block |
| adv_i | input | 1 | High on cycles in which an instruction completes |
| issue_i | input | 1 | High for one cycle when a disable-for-N instruction executes |
| op_i | input | 14 | N operand, sampled when issue_i is high |
| inhibit_o | output | 1 | Interrupt acceptance must be blocked |
| busy_o | output | 1 | Countdown is running |

## Verification
The hardest case to reach is the re-issue on the exact cycle in which the count has just become zero. The stimulus must place the issue pulse with one-cycle precision after N advancing cycles, and any stall in between moves the target cycle. The bench drives that case with several operands, places stalls before it, and adds the neighbouring cases one cycle early and one cycle late. A behavioural reference compared on every cycle then shows any gap in the inhibit line.

// File: rtl/tid_pkg.sv
package tid_pkg;
  localparam int OP_W_DEF = 14;
endpackage

// File: rtl/tid_count.sv
module tid_count #(
  parameter int W = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         nz_o
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  // Next state: a load wins over the decrement, so a load in the cycle the
  // count becomes zero is never dropped.
  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (load_i) begin
      cnt_d  = load_val_i;
      cnt_en = 1'b1;
    end else if (adv_i && (cnt_q != '0)) begin
      cnt_d  = cnt_q - W'(1);
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign nz_o = (cnt_q != '0);
endmodule

// File: rtl/tid_gate.sv
module tid_gate (
  input  logic issue_i,
  input  logic nz_i,
  output logic inhibit_o,
  output logic busy_o
);
  // The issue cycle is blocked directly, before the counter holds the value.
  always_comb begin
    inhibit_o = issue_i | nz_i;
    busy_o    = nz_i;
  end
endmodule

// File: rtl/tid_holdoff.sv
module tid_holdoff #(
  parameter int OP_W = tid_pkg::OP_W_DEF
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            adv_i,
  input  logic            issue_i,
  input  logic [OP_W-1:0] op_i,
  output logic            inhibit_o,
  output logic            busy_o
);
  logic cnt_nz;

  tid_count #(.W(OP_W)) u_count (
    .clk        (clk),
    .rst_n      (rst_n),
    .adv_i      (adv_i),
    .load_i     (issue_i),
    .load_val_i (op_i),
    .nz_o       (cnt_nz)
  );

  tid_gate u_gate (
    .issue_i   (issue_i),
    .nz_i      (cnt_nz),
    .inhibit_o (inhibit_o),
    .busy_o    (busy_o)
  );
endmodule

// File: rtl/tid_holdoff_chk.sv
module tid_holdoff_chk #(
  parameter int OP_W = 14
) (
  input logic            clk,
  input logic            rst_n,
  input logic            adv_i,
  input logic            issue_i,
  input logic [OP_W-1:0] op_i,
  input logic            inhibit_o,
  input logic            busy_o
);
  // R2: issue cycle always blocked
  a_r2_issue_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    issue_i |-> inhibit_o);
  // R5 / R6: a non-zero load always arms the counter
  a_r5_load_arms: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && op_i != '0) |=> busy_o);
  // R4: a stall freezes a running count
  a_r4_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv_i && !issue_i && busy_o) |=> (busy_o && inhibit_o));
  // R8: busy implies inhibit
  a_r8_busy_inhibits: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> inhibit_o);
  // R7: zero operand leaves the counter idle
  a_r7_zero_op_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && op_i == '0) |=> !busy_o);
  // R4: the count ends only after an advancing cycle
  a_r4_end_on_adv: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> $past(adv_i));
endmodule

bind tid_holdoff tid_holdoff_chk #(.OP_W(OP_W)) u_chk (.*);

// File: tb/tid_holdoff_bench.sv
`timescale 1ns/1ps
module tid_holdoff_bench;
  localparam int OP_W = 14;
  logic clk = 1'b0;
  logic rst_n, adv, iss;
  logic [OP_W-1:0] op;
  logic inh, busy;
  int checks = 0, fails = 0;
  int m_cnt = 0;
  int win = 0;

  always #5 clk = ~clk;

  tid_holdoff #(.OP_W(OP_W)) u_tid_holdoff (
    .clk(clk), .rst_n(rst_n), .adv_i(adv), .issue_i(iss), .op_i(op),
    .inhibit_o(inh), .busy_o(busy)
  );

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_int(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // One cycle: drive at negedge, compare with the reference, then advance it.
  task automatic cyc(input logic a, input logic i, input int o, input string tag);
    @(negedge clk);
    adv = a; iss = i; op = OP_W'(o);
    #1;
    chk(inh, (i || m_cnt != 0), {tag, " inhibit"});
    chk(busy, (m_cnt != 0), {tag, " busy"});
    if (inh) win++;
    @(posedge clk);
    if (i) m_cnt = o;
    else if (a && m_cnt > 0) m_cnt = m_cnt - 1;
  endtask

  task automatic idle(input int n, input string tag);
    for (int k = 0; k < n; k++) cyc(1'b1, 1'b0, 0, tag);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; adv = 1'b0; iss = 1'b0; op = '0;
    repeat (3) @(posedge clk);
    #1;
    chk(inh, 1'b0, "R1 reset inhibit");
    chk(busy, 1'b0, "R1 reset busy");
    @(negedge clk); rst_n = 1'b1;
    idle(2, "R1");

    // R2, R3: N=5 gives 6 cycles
    win = 0;
    cyc(1, 1, 5, "R2");
    idle(8, "R3");
    chk_int(win, 6, "R3 window N=5");

    // R7: zero operand
    win = 0;
    cyc(1, 1, 0, "R7");
    idle(3, "R7");
    chk_int(win, 1, "R7 window N=0");

    // R4: stalls stretch the window
    win = 0;
    cyc(1, 1, 3, "R4");
    cyc(0, 0, 0, "R4"); cyc(0, 0, 0, "R4");
    idle(1, "R4");
    cyc(0, 0, 0, "R4");
    idle(5, "R4");
    chk_int(win, 7, "R4 stretched window");

    // R5: reissue mid-count
    win = 0;
    cyc(1, 1, 4, "R5");
    idle(2, "R5");
    cyc(1, 1, 6, "R5");
    idle(9, "R5");
    chk_int(win, 10, "R5 reload window");

    // R6: reissue exactly when the count reaches zero, several operands
    for (int n = 1; n <= 4; n++) begin
      win = 0;
      cyc(1, 1, n, "R6");
      idle(n, "R6");
      cyc(1, 1, 2, "R6");
      idle(5, "R6");
      chk_int(win, n + 1 + 3, "R6 gapless reengage");
    end
    // R6 with a stall before the zero cycle
    win = 0;
    cyc(1, 1, 2, "R6");
    cyc(0, 0, 0, "R6");
    idle(2, "R6");
    cyc(1, 1, 3, "R6");
    idle(6, "R6");
    chk_int(win, 8, "R6 stalled reengage");

    // R9: issue one cycle after expiry
    win = 0;
    cyc(1, 1, 2, "R9");
    idle(3, "R9");
    chk_int(win, 3, "R9 first window");
    win = 0;
    cyc(1, 1, 3, "R9");
    idle(5, "R9");
    chk_int(win, 4, "R9 fresh window");

    // R8: mixed traffic checked every cycle
    cyc(0, 1, 2, "R8");
    cyc(0, 0, 0, "R8");
    idle(1, "R8");
    cyc(1, 1, 1, "R8");
    idle(3, "R8");

    // R10: largest operand
    win = 0;
    cyc(1, 1, 16383, "R10");
    idle(16386, "R10");
    chk_int(win, 16384, "R10 max window");

    finish_run();
  end
endmodule